// File: doc/BRIEF.md
# Byte-Skipping Sequential Shifter

This block shifts a 16-bit operand over several clock cycles. It suits a narrow datapath that can only move data one bit per step. The operand is held as an upper and a lower byte register. A single-bit step carries one bit across the boundary between them. For a count of eight or more, one cycle moves a whole byte from one register to the other. That cycle takes the place of eight single steps, so a large shift can finish sooner than a mid-sized one.

A start pulse loads the operand together with a 5-bit count (four count bits plus an overflow bit), a direction and a mode. The mode is logical or arithmetic and only matters for right shifts. The controller has two states:

- `ST_IDLE` accepts a start. It moves to `ST_WORK` when the count is nonzero. A zero count is answered at once.
- `ST_WORK` runs one operation per cycle: a full fill, a byte move or a single step. It returns to `ST_IDLE` on the cycle in which the remaining count reaches zero.

When the shift ends, `done` pulses and `cycles` reports how many cycles the operation took.

Top module: `byte_skip_shifter`

## Requirements
- R1: A left shift by N (N 0..15) returns operand << N. The lower register's bit 7 carries into the upper register's bit 0, and vacated low bits are 0.
- R2: A logical right shift (arith=0) by N (N 0..15) returns operand >> N with zeros in the vacated high bits.
- R3: An arithmetic right shift (arith=1) copies operand bit 15 into every vacated high bit.
- R4: For N from 0 to 7, done rises N+1 cycles after the start cycle. For N=0, the result equals the operand.
- R5: For N from 8 to 15, one byte move replaces eight steps and done rises N-6 cycles after the start cycle.
- R6: After a left byte move, the result does not depend on the original upper byte.
- R7: A count of 16 or more returns 0 for left and logical right shifts, and sixteen copies of bit 15 for arithmetic right shifts. Done rises 2 cycles after start.
- R8: busy is 1 in every cycle after an accepted start up to the done cycle, and is 0 in the done cycle. A start while busy is 1 is ignored.
- R9: done is a one-cycle pulse. result changes only in a done cycle and otherwise holds.
- R10: cycles reports the start-to-done latency of the last operation and changes only with done. After reset, busy, done, result and cycles are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled while idle |
| operand | input | 16 | Value to shift |
| count | input | 5 | Shift distance, 0..31 |
| dir_right | input | 1 | 1 = right shift, 0 = left shift |
| arith | input | 1 | 1 = sign fill on right shifts |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted value, held between completions |
| cycles | output | 5 | Latency of the last operation |

## Verification
The bench builds the block with its default 8-bit halves and 5-bit count, so the count can reach every value from 0 to 31. The vectors cover all three latency regimes: pure stepping, a byte move followed by steps, and the single-cycle fill for counts of 16 or more. They include the slowest case, 15, at nine cycles, and show that a count of 8 finishes faster than a count of 7. Directed cases pair operands that differ only in the upper byte. They also try a start pulse in the middle of an operation and check that the result holds across idle and busy cycles.

// File: rtl/bss_pkg.sv
package bss_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WORK = 1'b1
    } state_t;
endpackage

// File: rtl/bss_bit_step.sv
module bss_bit_step #(
    parameter int HALF_W = 8
) (
    input  logic [HALF_W-1:0] hi_i,
    input  logic [HALF_W-1:0] lo_i,
    input  logic              right_i,
    input  logic              fill_i,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] lo_o
);
    always_comb begin
        if (right_i) begin
            hi_o = {fill_i, hi_i[HALF_W-1:1]};
            lo_o = {hi_i[0], lo_i[HALF_W-1:1]};
        end else begin
            hi_o = {hi_i[HALF_W-2:0], lo_i[HALF_W-1]};
            lo_o = {lo_i[HALF_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/bss_byte_move.sv
module bss_byte_move #(
    parameter int HALF_W = 8
) (
    input  logic [HALF_W-1:0] hi_i,
    input  logic [HALF_W-1:0] lo_i,
    input  logic              right_i,
    input  logic              fill_i,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] lo_o
);
    always_comb begin
        if (right_i) begin
            hi_o = {HALF_W{fill_i}};
            lo_o = hi_i;
        end else begin
            hi_o = lo_i;
            lo_o = '0;
        end
    end
endmodule

// File: rtl/byte_skip_shifter.sv
module byte_skip_shifter
    import bss_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int CNT_W  = 5,
    parameter int CYC_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2*HALF_W-1:0]   operand,
    input  logic [CNT_W-1:0]      count,
    input  logic                  dir_right,
    input  logic                  arith,
    output logic                  busy,
    output logic                  done,
    output logic [2*HALF_W-1:0]   result,
    output logic [CYC_W-1:0]      cycles
);
    localparam int DATA_W = 2 * HALF_W;

    state_t st_q, st_d;

    logic [HALF_W-1:0] hi_q, lo_q;
    logic [CNT_W-1:0]  rem_q;
    logic              right_q, arith_q;
    logic [CYC_W-1:0]  run_q;

    logic              fill_bit;
    logic [HALF_W-1:0] step_hi, step_lo, move_hi, move_lo;
    logic [HALF_W-1:0] nxt_hi, nxt_lo;
    logic [CNT_W-1:0]  nxt_rem;
    logic              accept, finish;

    assign fill_bit = right_q & arith_q & hi_q[HALF_W-1];
    assign accept   = start && (st_q == ST_IDLE);
    assign busy     = (st_q == ST_WORK);

    bss_bit_step #(.HALF_W(HALF_W)) u_step (
        .hi_i    (hi_q),
        .lo_i    (lo_q),
        .right_i (right_q),
        .fill_i  (fill_bit),
        .hi_o    (step_hi),
        .lo_o    (step_lo)
    );

    bss_byte_move #(.HALF_W(HALF_W)) u_move (
        .hi_i    (hi_q),
        .lo_i    (lo_q),
        .right_i (right_q),
        .fill_i  (fill_bit),
        .hi_o    (move_hi),
        .lo_o    (move_lo)
    );

    // Pick the work done in this cycle: full fill, byte move or single step.
    always_comb begin
        if (rem_q >= CNT_W'(DATA_W)) begin
            nxt_hi  = {HALF_W{fill_bit}};
            nxt_lo  = {HALF_W{fill_bit}};
            nxt_rem = '0;
        end else if (rem_q >= CNT_W'(HALF_W)) begin
            nxt_hi  = move_hi;
            nxt_lo  = move_lo;
            nxt_rem = rem_q - CNT_W'(HALF_W);
        end else begin
            nxt_hi  = step_hi;
            nxt_lo  = step_lo;
            nxt_rem = rem_q - CNT_W'(1);
        end
        finish = (nxt_rem == '0);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept && (count != '0)) st_d = ST_WORK;
            ST_WORK: if (finish) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            rem_q   <= '0;
            right_q <= 1'b0;
            arith_q <= 1'b0;
            run_q   <= '0;
            done    <= 1'b0;
            result  <= '0;
            cycles  <= '0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        hi_q    <= operand[DATA_W-1:HALF_W];
                        lo_q    <= operand[HALF_W-1:0];
                        rem_q   <= count;
                        right_q <= dir_right;
                        arith_q <= arith;
                        run_q   <= CYC_W'(1);
                        if (count == '0) begin
                            result <= operand;
                            done   <= 1'b1;
                            cycles <= CYC_W'(1);
                        end
                    end
                end
                ST_WORK: begin
                    hi_q  <= nxt_hi;
                    lo_q  <= nxt_lo;
                    rem_q <= nxt_rem;
                    run_q <= run_q + CYC_W'(1);
                    if (finish) begin
                        result <= {nxt_hi, nxt_lo};
                        done   <= 1'b1;
                        cycles <= run_q + CYC_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
    parameter int HALF_W = 8,
    parameter int CYC_W  = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic [2*HALF_W-1:0] result,
    input logic [CYC_W-1:0]    cycles
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    assert_cycles_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cycles) |-> done);

    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_latency_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles != '0) && (cycles <= CYC_W'(HALF_W + 1)));
endmodule

bind byte_skip_shifter bss_checker #(.HALF_W(HALF_W), .CYC_W(CYC_W)) u_bss_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .result (result),
    .cycles (cycles)
);

// File: tb/byte_skip_shifter_test.sv
`timescale 1ns/1ps
module byte_skip_shifter_test;
    typedef struct packed {
        logic [15:0] op;
        logic [4:0]  cnt;
        logic        rt;
        logic        ar;
        logic [4:0]  lat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'hA5C3, 5'd0,  1'b0, 1'b0, 5'd1},  // R4 zero count
        '{16'h8001, 5'd1,  1'b0, 1'b0, 5'd2},  // R1 carry across halves
        '{16'h00FF, 5'd3,  1'b1, 1'b0, 5'd4},  // R2
        '{16'h1234, 5'd7,  1'b0, 1'b0, 5'd8},  // R1 R4
        '{16'hABCD, 5'd8,  1'b0, 1'b0, 5'd2},  // R5 byte move only
        '{16'hABCD, 5'd10, 1'b0, 1'b0, 5'd4},  // R5 move plus two steps
        '{16'h8400, 5'd10, 1'b1, 1'b1, 5'd4},  // R3 R5
        '{16'h8400, 5'd10, 1'b1, 1'b0, 5'd4},  // R2 R5
        '{16'hF0F0, 5'd15, 1'b1, 1'b1, 5'd9},  // R3 longest
        '{16'h7FFF, 5'd15, 1'b1, 1'b1, 5'd9},  // R3 positive
        '{16'hFFFF, 5'd16, 1'b0, 1'b0, 5'd2},  // R7
        '{16'h8000, 5'd20, 1'b1, 1'b1, 5'd2},  // R7 sign fill
        '{16'h8000, 5'd31, 1'b1, 1'b0, 5'd2},  // R7 logical
        '{16'h8001, 5'd5,  1'b1, 1'b1, 5'd6}   // R3 R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] operand = '0;
    logic [4:0]  count = '0;
    logic        dir_right = 1'b0;
    logic        arith = 1'b0;
    logic        busy, done;
    logic [15:0] result;
    logic [4:0]  cycles;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    byte_skip_shifter uut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .count(count), .dir_right(dir_right), .arith(arith),
        .busy(busy), .done(done), .result(result), .cycles(cycles)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(logic [15:0] op, logic [4:0] c, logic rt, logic ar);
        if (!rt) return (c >= 16) ? 16'h0 : (op << c);
        if (!ar) return (c >= 16) ? 16'h0 : (op >> c);
        if (c >= 16) return {16{op[15]}};
        return 16'($signed(op) >>> c);
    endfunction

    task automatic run_op(input logic [15:0] op, input logic [4:0] c, input logic rt,
                          input logic ar, output int lat, output bit busy_bad);
        @(negedge clk);
        operand = op; count = c; dir_right = rt; arith = ar; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        busy_bad = 0;
        while (!done && lat < 40) begin
            if (!busy) busy_bad = 1;
            @(negedge clk);
            lat++;
        end
        if (busy) busy_bad = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        bit bb;
        logic [15:0] held, r_a, r_b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R10 reset result", result, 0);
        chk("R10 reset cycles", cycles, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = !VECS[i].rt ? "R1" : (VECS[i].ar ? "R3" : "R2");
            if (VECS[i].cnt >= 16) tag = "R7";
            run_op(VECS[i].op, VECS[i].cnt, VECS[i].rt, VECS[i].ar, lat, bb);
            chk({tag, " result"}, result, model(VECS[i].op, VECS[i].cnt, VECS[i].rt, VECS[i].ar));
            chk((VECS[i].cnt < 8) ? "R4 latency" : "R5 latency", lat, VECS[i].lat);
            chk("R10 cycles port", cycles, VECS[i].lat);
            chk("R8 busy window", bb, 0);
        end

        // R9 done is one cycle; result holds while idle
        held = result;
        @(negedge clk);
        chk("R9 done pulse", done, 0);
        repeat (3) @(negedge clk);
        chk("R9 result hold idle", result, held);

        // R6 result after byte move ignores the original upper byte
        run_op(16'h12AB, 5'd9, 1'b0, 1'b0, lat, bb);
        r_a = result;
        run_op(16'hFFAB, 5'd9, 1'b0, 1'b0, lat, bb);
        r_b = result;
        chk("R6 upper byte ignored", r_b, r_a);
        chk("R6 value", r_a, 16'h5600);

        // R8 start while busy is ignored; R9 result holds during busy
        held = result;
        @(negedge clk);
        operand = 16'h0001; count = 5'd7; dir_right = 1'b0; arith = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R9 result hold busy", result, held);
        operand = 16'hFFFF; count = 5'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R8 ignored start gives no done", done, 0);
        lat = 3;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 original op latency", lat, 8);
        chk("R8 original op result", result, 16'h0080);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule